// File: doc/BRIEF.md
# Circular Receive Packet Buffer Manager

This block keeps the pointers for a circular receive buffer in packet memory, filled by an Ethernet-style receive path. The receive path sends one strobe per incoming byte. It then ends each packet with a done strobe or a fail strobe. The block supplies the memory write enable and the address for each byte. It moves a host-visible write pointer forward only when a packet has arrived in full. The host frees space by moving the read pointer, and it retires finished packets by sending a decrement command.

The writer never catches up with the host's read pointer. If a byte would leave the writer on the read pointer, the packet in progress is abandoned. The same happens to any new packet while the pending-packet count is saturated. In both cases a sticky receive-error flag is raised, and it can drive an interrupt. A free-space figure is always available, and it keeps one byte of the ring in reserve.

Top module: `rx_ring_ctrl`

## Requirements
- R1: A byte strobe writes at the current write address, and that address then steps to the next location. If the next location equals the read pointer, the byte is not written (mem_we low) and the packet is aborted. An aborted packet returns the current address to the committed write pointer and sets rx_err. Further bytes of that packet are dropped, and its closing done strobe commits nothing.
- R2: The committed write pointer wr_ptr changes only on a successful done strobe or on a configuration load. A successful done loads it with the current write address, which is the location after the packet's last byte. It is updated one clock after the strobe.
- R3: The write address steps from the upper bound back to the lower bound. Both bounds are inclusive.
- R4: host_dec lowers pkt_cnt by 1. When pkt_cnt is 0, host_dec has no effect.
- R5: A successful done sets pkt_pend and raises pkt_cnt by 1. A decrement that takes pkt_cnt to 0 clears pkt_pend. Any other decrement leaves pkt_pend set.
- R6: While pkt_cnt is 255, any byte strobe or done strobe of a packet that is not already dropped aborts that packet, as in R1, even when space is free.
- R7: pkt_fail returns the current address to wr_ptr without setting rx_err, and it ends any dropping.
- R8: Let W be wr_ptr and R be rd_ptr. free_bytes is (hi-lo)-(W-R) when W>R, hi-lo when W=R, and R-W-1 when W<R.
- R9: rx_err stays set until err_clr. A new abort in the same cycle as err_clr wins. irq equals rx_err AND int_en.
- R10: cfg_load sets the bounds to cfg_lo and cfg_hi. It places rd_ptr, wr_ptr and the current address at cfg_lo. This is the only way the write pointer can equal the read pointer by other than a drained buffer.
- R11: If a successful done and an effective host_dec fall in the same cycle, pkt_cnt is unchanged and pkt_pend stays set.
- R12: After reset, the bounds are 0 and 2**AW-1. All pointers are 0, pkt_cnt is 0, and pkt_pend and rx_err are clear.
- R13: rdp_wr loads rd_ptr from rdp_val on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load bounds and reset pointers |
| cfg_lo | input | AW | Lower bound of the ring |
| cfg_hi | input | AW | Upper bound of the ring (inclusive) |
| rdp_wr | input | 1 | Host read-pointer write |
| rdp_val | input | AW | New read-pointer value |
| host_dec | input | 1 | Retire one pending packet |
| err_clr | input | 1 | Clear receive-error flag |
| int_en | input | 1 | Interrupt enable |
| byte_stb | input | 1 | Receive path delivers one byte |
| pkt_done | input | 1 | Packet ended correctly |
| pkt_fail | input | 1 | Packet ended with an error |
| mem_we | output | 1 | Memory write enable for this byte |
| mem_addr | output | AW | Current write address |
| wr_ptr | output | AW | Committed write pointer |
| rd_ptr | output | AW | Host read pointer |
| pkt_cnt | output | CW | Pending packet count |
| pkt_pend | output | 1 | Packets waiting |
| rx_err | output | 1 | Sticky receive error |
| irq | output | 1 | Interrupt |
| free_bytes | output | AW | Free space in bytes |

## Verification
mem_addr shows the in-progress address directly. An error in stepping, wrapping or rollback therefore appears in the same cycle as the following byte strobe. A wrong collision or saturation decision appears one clock later, as an rx_err mismatch. It also shows as a mem_we that is asserted or missing in the next strobe cycle. Counter and flag errors appear on pkt_cnt and pkt_pend one clock after the command. Pointer errors appear at once in free_bytes, because that output is combinational.

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl #(
  parameter int AW = 10,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_lo,
  input  logic [AW-1:0] cfg_hi,
  input  logic          rdp_wr,
  input  logic [AW-1:0] rdp_val,
  input  logic          host_dec,
  input  logic          err_clr,
  input  logic          int_en,
  input  logic          byte_stb,
  input  logic          pkt_done,
  input  logic          pkt_fail,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] pkt_cnt,
  output logic          pkt_pend,
  output logic          rx_err,
  output logic          irq,
  output logic [AW-1:0] free_bytes
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [AW-1:0] lo_q, hi_q, cur_q, wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          pend_q, err_q, drop_q;

  logic [AW-1:0] cur_nx, span;
  logic          sat, live, byte_abort, done_abort, commit, dec_eff, abort;

  assign cur_nx     = (cur_q == hi_q) ? lo_q : cur_q + 1'b1;
  assign sat        = (cnt_q == CNT_MAX);
  assign live       = !drop_q && !pkt_fail;
  assign byte_abort = byte_stb && !pkt_done && live && (sat || cur_nx == rp_q);
  assign done_abort = pkt_done && live && sat;
  assign commit     = pkt_done && live && !sat;
  assign abort      = byte_abort || done_abort;
  assign dec_eff    = host_dec && (cnt_q != '0);

  assign mem_we   = byte_stb && !pkt_done && live && !sat && (cur_nx != rp_q);
  assign mem_addr = cur_q;
  assign wr_ptr   = wp_q;
  assign rd_ptr   = rp_q;
  assign pkt_cnt  = cnt_q;
  assign pkt_pend = pend_q;
  assign rx_err   = err_q;
  assign irq      = err_q && int_en;

  assign span       = hi_q - lo_q;
  assign free_bytes = (wp_q > rp_q)  ? span - (wp_q - rp_q) :
                      (wp_q == rp_q) ? span : rp_q - wp_q - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '1;
      cur_q  <= '0;
      wp_q   <= '0;
      rp_q   <= '0;
      drop_q <= 1'b0;
    end else if (cfg_load) begin
      lo_q   <= cfg_lo;
      hi_q   <= cfg_hi;
      cur_q  <= cfg_lo;
      wp_q   <= cfg_lo;
      rp_q   <= cfg_lo;
      drop_q <= 1'b0;
    end else begin
      if (rdp_wr) rp_q <= rdp_val;
      if (pkt_fail) begin
        cur_q  <= wp_q;
        drop_q <= 1'b0;
      end else if (pkt_done) begin
        drop_q <= 1'b0;
        if (commit) wp_q <= cur_q;
        else        cur_q <= wp_q;
      end else if (byte_abort) begin
        cur_q  <= wp_q;
        drop_q <= 1'b1;
      end else if (mem_we) begin
        cur_q  <= cur_nx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (commit && !dec_eff)      cnt_q <= cnt_q + 1'b1;
      else if (dec_eff && !commit) cnt_q <= cnt_q - 1'b1;
      if (commit)                                  pend_q <= 1'b1;
      else if (dec_eff && cnt_q == {{(CW-1){1'b0}}, 1'b1}) pend_q <= 1'b0;
      if (abort)        err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  a_r1_drop_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q && byte_stb) |-> !mem_we);
  a_r2_wptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !cfg_load) |=> $stable(wp_q));
  a_r3_addr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && lo_q <= hi_q) |-> (cur_q >= lo_q && cur_q <= hi_q));
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && host_dec && !commit) |=> (cnt_q == '0));
  a_r5_pend_tracks_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q == (cnt_q != '0));
  a_r8_free_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_q <= hi_q) |-> (free_bytes <= span));
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);
  a_r11_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && dec_eff) |=> $stable(cnt_q));
endmodule

// File: tb/tb_rx_ring_ctrl.sv
`timescale 1ns/1ps
module tb_rx_ring_ctrl;
  localparam int AW = 10;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 0, rdp_wr = 0, host_dec = 0, err_clr = 0, int_en = 0;
  logic byte_stb = 0, pkt_done = 0, pkt_fail = 0;
  logic [AW-1:0] cfg_lo = '0, cfg_hi = '0, rdp_val = '0;
  logic mem_we, pkt_pend, rx_err, irq;
  logic [AW-1:0] mem_addr, wr_ptr, rd_ptr, free_bytes;
  logic [CW-1:0] pkt_cnt;

  always #2 clk = ~clk;

  rx_ring_ctrl #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .rdp_wr(rdp_wr), .rdp_val(rdp_val), .host_dec(host_dec), .err_clr(err_clr),
    .int_en(int_en), .byte_stb(byte_stb), .pkt_done(pkt_done), .pkt_fail(pkt_fail),
    .mem_we(mem_we), .mem_addr(mem_addr), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .pkt_cnt(pkt_cnt), .pkt_pend(pkt_pend), .rx_err(rx_err), .irq(irq),
    .free_bytes(free_bytes));

  int total = 0, bad = 0;
  logic [AW-1:0] m_lo, m_hi, m_rd, m_w, m_cur;
  int m_cnt;
  bit m_pend, m_err, m_drop, m_ie;

  function automatic logic [AW-1:0] f_inc(input logic [AW-1:0] a);
    return (a == m_hi) ? m_lo : a + 1'b1;
  endfunction

  function automatic logic [AW-1:0] f_free();
    logic [AW-1:0] s;
    s = m_hi - m_lo;
    if (m_w > m_rd) return s - (m_w - m_rd);
    if (m_w == m_rd) return s;
    return m_rd - m_w - 1'b1;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    chk(req, "R2 wr_ptr", wr_ptr, m_w);
    chk(req, "R13 rd_ptr", rd_ptr, m_rd);
    chk(req, "R4 pkt_cnt", pkt_cnt, m_cnt);
    chk(req, "R5 pkt_pend", pkt_pend, m_pend);
    chk(req, "R1 rx_err", rx_err, m_err);
    chk(req, "R9 irq", irq, m_err && m_ie);
    chk(req, "R3 mem_addr", mem_addr, m_cur);
    chk(req, "R8 free_bytes", free_bytes, f_free());
  endtask

  task automatic cyc(input string req, input bit b, input bit d, input bit f,
                     input bit dec, input bit rw, input logic [AW-1:0] rv,
                     input bit ec, input bit cl, input logic [AW-1:0] clo,
                     input logic [AW-1:0] chi);
    bit sat, we_e, commit, ab_b, ab_d, dec_e;
    logic [AW-1:0] nx;
    @(negedge clk);
    byte_stb = b; pkt_done = d; pkt_fail = f; host_dec = dec; rdp_wr = rw;
    rdp_val = rv; err_clr = ec; cfg_load = cl; cfg_lo = clo; cfg_hi = chi; int_en = m_ie;
    #1;
    sat    = (m_cnt == 255);
    nx     = f_inc(m_cur);
    we_e   = b && !d && !f && !m_drop && !sat && nx != m_rd;
    chk(req, "R1 mem_we", mem_we, we_e);
    ab_b   = b && !d && !f && !m_drop && (sat || nx == m_rd);
    ab_d   = d && !f && !m_drop && sat;
    commit = d && !f && !m_drop && !sat;
    dec_e  = dec && m_cnt != 0;
    if (commit && !dec_e) m_cnt++;
    else if (dec_e && !commit) m_cnt--;
    if (commit) m_pend = 1;
    else if (dec_e && m_cnt == 0) m_pend = 0;
    if (ab_b || ab_d) m_err = 1;
    else if (ec) m_err = 0;
    if (cl) begin
      m_lo = clo; m_hi = chi; m_rd = clo; m_w = clo; m_cur = clo; m_drop = 0;
    end else begin
      if (rw) m_rd = rv;
      if (f) begin m_cur = m_w; m_drop = 0; end
      else if (d) begin
        m_drop = 0;
        if (commit) m_w = m_cur; else m_cur = m_w;
      end else if (ab_b) begin m_cur = m_w; m_drop = 1; end
      else if (we_e) m_cur = nx;
    end
    @(posedge clk); #1;
    check_regs(req);
  endtask

  task automatic idle(input string req);
    cyc(req, 0, 0, 0, 0, 0, '0, 0, 0, '0, '0);
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_lo = '0; m_hi = '1; m_rd = '0; m_w = '0; m_cur = '0;
    m_cnt = 0; m_pend = 0; m_err = 0; m_drop = 0; m_ie = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12 reset state
    @(negedge clk);
    check_regs("R12");
    chk("R12", "free_bytes", free_bytes, (1 << AW) - 1);

    // R10 configure a 32-byte ring
    cyc("R10", 0, 0, 0, 0, 0, '0, 0, 1, 10'd16, 10'd47);
    chk("R10", "mem_addr", mem_addr, 16);

    // R2: five bytes then done
    for (int i = 0; i < 5; i++) cyc("R2", 1, 0, 0, 0, 0, '0, 0, 0, '0, '0);
    chk("R2", "wr_ptr before done", wr_ptr, 16);
    cyc("R2", 0, 1, 0, 0, 0, '0, 0, 0, '0, '0);
    chk("R2", "wr_ptr after done", wr_ptr, 21);
    chk("R5", "pend", pkt_pend, 1);
    // R4 decrement then decrement at zero
    cyc("R4", 0, 0, 0, 1, 0, '0, 0, 0, '0, '0);
    chk("R5", "pend cleared", pkt_pend, 0);
    cyc("R4", 0, 0, 0, 1, 0, '0, 0, 0, '0, '0);
    chk("R4", "cnt stays 0", pkt_cnt, 0);

    // R7 fail rolls back without error
    for (int i = 0; i < 3; i++) cyc("R7", 1, 0, 0, 0, 0, '0, 0, 0, '0, '0);
    cyc("R7", 0, 0, 1, 0, 0, '0, 0, 0, '0, '0);
    chk("R7", "addr rolled back", mem_addr, 21);
    chk("R7", "no error", rx_err, 0);

    // R3 and R1: drain, then fill until collision, wrapping past 47
    cyc("R13", 0, 0, 0, 0, 1, 10'd21, 0, 0, '0, '0);
    for (int i = 0; i < 40; i++) cyc("R1", 1, 0, 0, 0, 0, '0, 0, 0, '0, '0);
    chk("R1", "collision error", rx_err, 1);
    chk("R1", "addr at commit", mem_addr, 21);
    cyc("R1", 0, 1, 0, 0, 0, '0, 0, 0, '0, '0);
    chk("R1", "dropped done no commit", pkt_cnt, 0);
    cyc("R9", 0, 0, 0, 0, 0, '0, 1, 0, '0, '0);
    chk("R9", "err cleared", rx_err, 0);
    // largest packet that fits: 31 bytes wrapping to 20
    for (int i = 0; i < 31; i++) cyc("R3", 1, 0, 0, 0, 0, '0, 0, 0, '0, '0);
    chk("R3", "wrapped addr", mem_addr, 20);
    cyc("R3", 0, 1, 0, 0, 0, '0, 0, 0, '0, '0);
    chk("R8", "ring full", free_bytes, 0);
    chk("R3", "no error on full fit", rx_err, 0);
    cyc("R4", 0, 0, 0, 1, 1, 10'd20, 0, 0, '0, '0);
    chk("R8", "drained", free_bytes, 31);

    // R6 saturate the counter with empty packets
    for (int i = 0; i < 255; i++) cyc("R6", 0, 1, 0, 0, 0, '0, 0, 0, '0, '0);
    chk("R6", "cnt max", pkt_cnt, 255);
    cyc("R6", 1, 0, 0, 0, 0, '0, 0, 0, '0, '0);
    chk("R6", "byte aborted", rx_err, 1);
    cyc("R6", 0, 1, 0, 0, 0, '0, 1, 0, '0, '0);
    chk("R6", "dropped done", pkt_cnt, 255);
    cyc("R6", 0, 1, 0, 0, 0, '0, 1, 0, '0, '0);
    chk("R9", "abort beats clear", rx_err, 1);
    m_ie = 0;
    cyc("R9", 0, 0, 0, 1, 0, '0, 0, 0, '0, '0);
    chk("R9", "irq masked", irq, 0);
    m_ie = 1;
    // R11 done plus decrement together
    cyc("R11", 0, 1, 0, 1, 0, '0, 0, 0, '0, '0);
    chk("R11", "cnt unchanged", pkt_cnt, 254);
    chk("R11", "pend set", pkt_pend, 1);
    for (int i = 0; i < 254; i++) cyc("R4", 0, 0, 0, 1, 0, '0, 0, 0, '0, '0);
    chk("R5", "pend after drain", pkt_pend, 0);

    // random traffic on a 64-byte ring
    cyc("R10", 0, 0, 0, 0, 0, '0, 0, 1, 10'd100, 10'd163);
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit b, d, f, dec, rw, ec;
      r = $urandom % 100;
      b = (r < 60); d = (r >= 60 && r < 72); f = (r >= 72 && r < 76);
      dec = ($urandom % 100) < 12;
      rw  = ($urandom % 100) < 6;
      ec  = ($urandom % 100) < 5;
      if (($urandom % 100) < 3) m_ie = !m_ie;
      cyc("RND", b, d, f, dec, rw, m_w, ec, 0, '0, '0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule